// File: doc/BRIEF.md
# Program Counter and Status Word Unit

This block keeps the program counter and the 8-bit processor status word of a small microcontroller core. Each cycle the program counter either stays put, moves forward by the byte length of the instruction just fetched, or takes a branch target. On reset it is loaded from the two reset-vector bytes, which the memory system presents on dedicated inputs.

The status word collects update strobes from the instruction decoder and the ALU. It can be overwritten with a byte popped from the stack, and its current value is always visible on an output so that it can be stacked. The same unit decides whether a maskable interrupt request may be taken. This decision uses the enable bit and the in-service priority field. Taking a request clears the enable bit at the next clock edge.

Top module: `cpu_pc_psw`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC loads `{4'h0, vec_hi, vec_lo}` and the status word loads 8'h06, so IE is 0 and the priority field is 2'b11.
- R2: The status word bits, from bit 7 down to bit 0, are IE, Z, RBS1, AC, RBS0, ISP1, ISP0, CY. `psw` always shows the whole word, and `bank` equals `{RBS1, RBS0}`.
- R3: When `fetch_en` is high and `br_en` is low, the PC advances by `fetch_len + 1` bytes, where `fetch_len` 0..3 stands for 1..4 bytes. The addition wraps modulo 2^20.
- R4: When `br_en` is high, the PC loads `br_target`, even if `fetch_en` is also high.
- R5: `di_cmd` clears IE and `ei_cmd` sets it. When both are high in the same cycle, IE ends up 0.
- R6: When `alu_we` is high, Z takes `alu_zero`, CY takes `alu_cy` and AC takes `alu_ac`. The other status bits stay unchanged.
- R7: When `bank_we` is high, RBS1 takes `bank_sel[1]` and RBS0 takes `bank_sel[0]`.
- R8: When `rest_en` is high, the status word loads `rest_val` in full. This overrides every other status update in that cycle, including an interrupt acceptance.
- R9: `irq_ack` is high in the same cycle exactly when IE is 1, `irq_req` is 1, `irq_mask` is 0 and `irq_lvl` is less than or equal to the priority field `{ISP1, ISP0}`. Level 0 is the highest priority.
- R10: An accepted request clears IE at the next edge. This takes precedence over an `ei_cmd` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vec_lo | input | 8 | Reset vector, low byte |
| vec_hi | input | 8 | Reset vector, high byte |
| fetch_en | input | 1 | An instruction was fetched this cycle |
| fetch_len | input | 2 | Fetched length minus one |
| br_en | input | 1 | Branch taken |
| br_target | input | 20 | Branch destination |
| di_cmd | input | 1 | Disable interrupts |
| ei_cmd | input | 1 | Enable interrupts |
| bank_we | input | 1 | Bank select command |
| bank_sel | input | 2 | New bank number |
| alu_we | input | 1 | ALU flag update strobe |
| alu_zero | input | 1 | ALU result is zero |
| alu_cy | input | 1 | ALU carry out |
| alu_ac | input | 1 | ALU auxiliary carry |
| rest_en | input | 1 | Restore the status word |
| rest_val | input | 8 | Restored status byte |
| irq_req | input | 1 | Maskable request pending |
| irq_mask | input | 1 | Request masked |
| irq_lvl | input | 2 | Request priority level |
| pc | output | 20 | Program counter |
| psw | output | 8 | Status word, for stacking |
| bank | output | 2 | Current register bank |
| irq_ack | output | 1 | Request accepted this cycle |

## Verification
The assertions assume that every strobe and data input is a known 0 or 1 whenever reset is released, and that `rst_n` changes only between clock edges. The bench meets this by changing all inputs on the falling edge. It returns every strobe to 0 before the next vector and holds the reset-vector inputs at defined values throughout. Priority collisions, such as a restore together with an acceptance and EI, or a branch together with a fetch, are created on purpose. In these cases the assertions and the bench model rely on the same stated order.

// File: rtl/cpu_pc_psw.sv
module cpu_pc_psw #(
  parameter int          PC_W    = 20,
  parameter logic [7:0]  PSW_RST = 8'h06
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      vec_lo,
  input  logic [7:0]      vec_hi,
  input  logic            fetch_en,
  input  logic [1:0]      fetch_len,
  input  logic            br_en,
  input  logic [PC_W-1:0] br_target,
  input  logic            di_cmd,
  input  logic            ei_cmd,
  input  logic            bank_we,
  input  logic [1:0]      bank_sel,
  input  logic            alu_we,
  input  logic            alu_zero,
  input  logic            alu_cy,
  input  logic            alu_ac,
  input  logic            rest_en,
  input  logic [7:0]      rest_val,
  input  logic            irq_req,
  input  logic            irq_mask,
  input  logic [1:0]      irq_lvl,
  output logic [PC_W-1:0] pc,
  output logic [7:0]      psw,
  output logic [1:0]      bank,
  output logic            irq_ack
);
  localparam int IE_B  = 7;
  localparam int Z_B   = 6;
  localparam int RB1_B = 5;
  localparam int AC_B  = 4;
  localparam int RB0_B = 3;
  localparam int ISP_H = 2;
  localparam int ISP_L = 1;
  localparam int CY_B  = 0;
  localparam int PAD_W = PC_W - 16;

  logic [PC_W-1:0] pc_q, pc_d, pc_step;
  logic [7:0]      psw_q, psw_d;
  logic [1:0]      isp;

  assign isp     = psw_q[ISP_H:ISP_L];
  assign irq_ack = psw_q[IE_B] & irq_req & ~irq_mask & (irq_lvl <= isp);
  assign pc_step = {{(PC_W-2){1'b0}}, fetch_len} + PC_W'(1);

  always_comb begin
    pc_d = pc_q;
    if (br_en)         pc_d = br_target;
    else if (fetch_en) pc_d = pc_q + pc_step;
  end

  always_comb begin
    psw_d = psw_q;
    if (alu_we) begin
      psw_d[Z_B]  = alu_zero;
      psw_d[CY_B] = alu_cy;
      psw_d[AC_B] = alu_ac;
    end
    if (bank_we) begin
      psw_d[RB1_B] = bank_sel[1];
      psw_d[RB0_B] = bank_sel[0];
    end
    if (di_cmd)      psw_d[IE_B] = 1'b0;
    else if (ei_cmd) psw_d[IE_B] = 1'b1;
    if (irq_ack)     psw_d[IE_B] = 1'b0;
    if (rest_en)     psw_d = rest_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= {{PAD_W{1'b0}}, vec_hi, vec_lo};
      psw_q <= PSW_RST;
    end else begin
      pc_q  <= pc_d;
      psw_q <= psw_d;
    end
  end

  assign pc   = pc_q;
  assign psw  = psw_q;
  assign bank = {psw_q[RB1_B], psw_q[RB0_B]};

  assert_reset_load_R1: assert property (@(posedge clk)
    !rst_n |=> (pc == {{PAD_W{1'b0}}, $past(vec_hi), $past(vec_lo)}) && (psw == PSW_RST));

  assert_fetch_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !br_en) |=> pc == $past(pc) + PC_W'($past(fetch_len)) + PC_W'(1));

  assert_branch_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_en |=> pc == $past(br_target));

  assert_di_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (di_cmd && !rest_en) |=> !psw[IE_B]);

  assert_alu_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && !rest_en) |=> psw[Z_B] == $past(alu_zero));

  assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rest_en |=> psw == $past(rest_val));

  assert_no_ack_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!psw[IE_B] || irq_mask) |-> !irq_ack);

  assert_ack_clears_ie_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !rest_en) |=> !psw[IE_B]);
endmodule

// File: tb/test_cpu_pc_psw.sv
module test_cpu_pc_psw;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  vec_lo, vec_hi;
  logic        fetch_en;
  logic [1:0]  fetch_len;
  logic        br_en;
  logic [19:0] br_target;
  logic        di_cmd, ei_cmd, bank_we;
  logic [1:0]  bank_sel;
  logic        alu_we, alu_zero, alu_cy, alu_ac;
  logic        rest_en;
  logic [7:0]  rest_val;
  logic        irq_req, irq_mask;
  logic [1:0]  irq_lvl;
  logic [19:0] pc;
  logic [7:0]  psw;
  logic [1:0]  bank;
  logic        irq_ack;

  cpu_pc_psw i_cpu_pc_psw (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [19:0] pc;
    logic [7:0]  psw;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [19:0] m_pc;
  logic [7:0]  m_psw;

  task automatic clr();
    rst_n = 1'b1; fetch_en = 0; fetch_len = 0; br_en = 0; br_target = 0;
    di_cmd = 0; ei_cmd = 0; bank_we = 0; bank_sel = 0;
    alu_we = 0; alu_zero = 0; alu_cy = 0; alu_ac = 0;
    rest_en = 0; rest_val = 0; irq_req = 0; irq_mask = 0; irq_lvl = 0;
  endtask

  task automatic vec_start();
    @(negedge clk);
    clr();
  endtask

  task automatic step(string tag, logic exp_ack);
    logic a;
    exp_t e;
    #1;
    a = m_psw[7] & irq_req & ~irq_mask & (irq_lvl <= m_psw[2:1]);
    n_chk++;
    if (irq_ack !== a || a !== exp_ack) begin
      n_bad++;
      $display("FAIL %s irq_ack actual %b expected %b (model %b)", tag, irq_ack, exp_ack, a);
    end
    if (!rst_n) begin
      m_pc  = {4'h0, vec_hi, vec_lo};
      m_psw = 8'h06;
    end else begin
      if (br_en)         m_pc = br_target;
      else if (fetch_en) m_pc = m_pc + 20'(fetch_len) + 20'd1;
      if (alu_we) begin m_psw[6] = alu_zero; m_psw[0] = alu_cy; m_psw[4] = alu_ac; end
      if (bank_we) begin m_psw[5] = bank_sel[1]; m_psw[3] = bank_sel[0]; end
      if (di_cmd) m_psw[7] = 1'b0; else if (ei_cmd) m_psw[7] = 1'b1;
      if (a) m_psw[7] = 1'b0;
      if (rest_en) m_psw = rest_val;
    end
    e.pc = m_pc; e.psw = m_psw; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (pc !== e.pc || psw !== e.psw || bank !== {e.psw[5], e.psw[3]}) begin
          n_bad++;
          $display("FAIL %s pc/psw/bank actual %h/%h/%b expected %h/%h/%b",
                   e.tag, pc, psw, bank, e.pc, e.psw, {e.psw[5], e.psw[3]});
        end
      end
    end
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_pc = 0; m_psw = 0;
    vec_hi = 8'hA5; vec_lo = 8'h3C;
    clr();
    rst_n = 1'b0;
    step("R1 reset", 1'b0);
    vec_start(); br_en = 1; br_target = 20'hFFFFF; step("R4 branch", 1'b0);
    vec_start(); rst_n = 0; step("R1 reset clears pc high bits", 1'b0);
    for (int i = 0; i < 4; i++) begin
      vec_start(); fetch_en = 1; fetch_len = 2'(i); step("R3 fetch length", 1'b0);
    end
    vec_start(); br_en = 1; br_target = 20'hFFFFE; step("R4 branch", 1'b0);
    vec_start(); fetch_en = 1; fetch_len = 2'd3; step("R3 wrap", 1'b0);
    vec_start(); br_en = 1; fetch_en = 1; fetch_len = 2'd1; br_target = 20'h12345;
    step("R4 branch over fetch", 1'b0);
    vec_start(); ei_cmd = 1; step("R5 EI", 1'b0);
    vec_start(); di_cmd = 1; step("R5 DI", 1'b0);
    vec_start(); ei_cmd = 1; di_cmd = 1; step("R5 DI wins", 1'b0);
    vec_start(); alu_we = 1; alu_zero = 1; alu_cy = 1; alu_ac = 1; step("R6 ALU flags set", 1'b0);
    vec_start(); alu_we = 1; alu_zero = 0; alu_cy = 1; alu_ac = 0; step("R6 ALU flags mixed", 1'b0);
    vec_start(); bank_we = 1; bank_sel = 2'b10; step("R7 R2 bank 2", 1'b0);
    vec_start(); bank_we = 1; bank_sel = 2'b01; step("R7 R2 bank 1", 1'b0);
    vec_start(); rest_en = 1; rest_val = 8'hA5; ei_cmd = 1; alu_we = 1; bank_we = 1;
    step("R8 restore overrides", 1'b0);
    vec_start(); rest_en = 1; rest_val = 8'h86; step("R8 restore", 1'b0);
    vec_start(); irq_req = 1; irq_lvl = 2'd3; ei_cmd = 1; step("R9 R10 accept lowest level", 1'b1);
    vec_start(); irq_req = 1; irq_lvl = 2'd0; step("R9 IE off no ack", 1'b0);
    vec_start(); rest_en = 1; rest_val = 8'h82; step("R8 restore isp1", 1'b0);
    vec_start(); irq_req = 1; irq_mask = 1; irq_lvl = 2'd0; step("R9 masked", 1'b0);
    vec_start(); irq_req = 1; irq_lvl = 2'd2; step("R9 level above isp", 1'b0);
    vec_start(); irq_req = 1; irq_lvl = 2'd1; rest_en = 1; rest_val = 8'hC3;
    step("R8 R9 restore beats ack", 1'b1);
    vec_start(); rest_en = 1; rest_val = 8'h82; step("R8 restore isp1", 1'b0);
    vec_start(); irq_req = 1; irq_lvl = 2'd1; step("R9 R10 level equal isp", 1'b1);
    vec_start(); step("R10 idle after ack", 1'b0);
    vec_start();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule